// File: doc/BRIEF.md
# Enabled Pulse Train Generator

This block produces a repeating rectangular wave on a single output while its enable input is high. The time spent high and the time spent low are each set by a 16-bit unsigned cycle count on separate inputs. Each time the train is switched on it begins with a rising edge and a full high phase, then alternates low and high phases for as long as enable stays high.

A count of zero is not skipped: it yields a phase of exactly one clock cycle, so both counts at zero give a wave that alternates every cycle. Each phase takes its length from the matching input at the moment the phase begins, so a length may be changed at any time without disturbing the phase already running. Dropping enable forces the output low in the same cycle and discards the count. Where no control is needed, the enable input is meant to be tied high, and the train then starts on the first clock edge after reset is released.

Top module: `pulse_train_gen`

## Requirements
- R1: While `rst_n` is low, and after reset while `enable` stays low, `pulse_out` is 0.
- R2: When `enable` is first sampled high at a rising clock edge, `pulse_out` is 1 from that edge onward, which starts the high phase.
- R3: With `high_len` = H >= 1, each high phase lasts exactly H clock cycles.
- R4: With `low_len` = L >= 1, each low phase lasts exactly L cycles, and the high/low pattern repeats with period H + L while `enable` stays high.
- R5: `high_len` = 0 gives a high phase of exactly one cycle.
- R6: `low_len` = 0 gives a low phase of exactly one cycle.
- R7: With both lengths at 0, `pulse_out` alternates every cycle: one cycle high, then one cycle low.
- R8: When `enable` is low, `pulse_out` is 0 in the same cycle. The phase count is discarded, so the next enable starts a fresh high phase of the full programmed length.
- R9: Each phase length is taken from `high_len` or `low_len` at the edge where that phase starts. A later change affects only phases that start afterwards.
- R10: With `enable` held high (the tie-off value) through reset, the high phase starts at the first rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the train while high; tie high if unused |
| high_len | input | 16 | High phase length in cycles (0 counts as 1) |
| low_len | input | 16 | Low phase length in cycles (0 counts as 1) |
| pulse_out | output | 1 | Generated pulse train |

## Verification
The train is run with several pairs of lengths: a symmetric pair, long high with short low, short high with long low, and each length at zero alone and both together. Comparing each output cycle against the H + L period separates the high count from the low count, and the zero cases separate the forced one-cycle phase from a phase that is skipped. Directed runs drop enable during a high phase to show the output clears at once and that re-enabling restarts a full phase. A length is changed partway through a phase to show it is sampled only when a phase begins. Enable is also held high through reset to cover the tie-off start.

// File: rtl/pulse_train_pkg.sv
// Shared types for the pulse train generator.
// Assumes: all users compile this package first.
package pulse_train_pkg;

    // Phase of the generator; IDLE means the train is stopped.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/pt_len_to_load.sv
// Converts a programmed phase length into a counter load value.
// A length of N (N >= 1) loads N-1; a length of 0 is treated as 1 and loads 0.
// Assumes: the counter ends a phase on the cycle it holds zero.
module pt_len_to_load #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] load_val
);

    // Clamp zero to a single cycle, otherwise subtract one.
    always_comb begin
        if (len_in == '0) begin
            load_val = '0;
        end else begin
            load_val = len_in - LEN_W'(1);
        end
    end

endmodule

// File: rtl/pt_down_counter.sv
// Down counter for the remaining cycles of the current phase.
// Clear has priority over load; otherwise it counts down and holds at zero.
// Assumes: synchronous active-low reset.
module pt_down_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             at_zero
);

    logic [LEN_W-1:0] cnt_q;

    // Track remaining cycles of the phase in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    // Flag the last cycle of a phase.
    always_comb begin
        at_zero = (cnt_q == '0);
    end

endmodule

// File: rtl/pt_phase_fsm.sv
// Phase sequencer: IDLE -> HIGH -> LOW -> HIGH ... while enabled.
// Requests a counter load on every phase entry and a clear when disabled.
// Assumes: at_zero marks the final cycle of the running phase.
module pt_phase_fsm
    import pulse_train_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   at_zero,
    output phase_e phase,
    output logic   load,
    output logic   sel_low,
    output logic   clear
);

    phase_e phase_q;
    phase_e phase_d;

    // Choose the next phase and the counter request for this cycle.
    always_comb begin
        phase_d = phase_q;
        load    = 1'b0;
        sel_low = 1'b0;
        clear   = 1'b0;
        if (!enable) begin
            phase_d = PH_IDLE;
            clear   = 1'b1;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_HIGH;
                    load    = 1'b1;
                end
                PH_HIGH: begin
                    if (at_zero) begin
                        phase_d = PH_LOW;
                        load    = 1'b1;
                        sel_low = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (at_zero) begin
                        phase_d = PH_HIGH;
                        load    = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                end
            endcase
        end
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Expose the registered phase.
    always_comb begin
        phase = phase_q;
    end

endmodule

// File: rtl/pulse_train_gen.sv
// Enabled pulse train generator: high for high_len cycles, low for low_len
// cycles, repeating while enable is high; zero lengths count as one cycle.
// Assumes: synchronous active-low reset; enable is tied high when unused.
module pulse_train_gen
    import pulse_train_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] high_len,
    input  logic [LEN_W-1:0] low_len,
    output logic             pulse_out
);

    logic [LEN_W-1:0] high_load;
    logic [LEN_W-1:0] low_load;
    logic [LEN_W-1:0] sel_load;
    logic             cnt_zero;
    logic             cnt_load;
    logic             cnt_clear;
    logic             load_low;
    phase_e           phase;

    pt_len_to_load #(.LEN_W(LEN_W)) u_high_len (
        .len_in   (high_len),
        .load_val (high_load)
    );

    pt_len_to_load #(.LEN_W(LEN_W)) u_low_len (
        .len_in   (low_len),
        .load_val (low_load)
    );

    // Pick the length of the phase being entered.
    always_comb begin
        sel_load = load_low ? low_load : high_load;
    end

    pt_down_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .load     (cnt_load),
        .load_val (sel_load),
        .at_zero  (cnt_zero)
    );

    pt_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .at_zero (cnt_zero),
        .phase   (phase),
        .load    (cnt_load),
        .sel_low (load_low),
        .clear   (cnt_clear)
    );

    // Drive the output; a low enable silences it in the same cycle.
    always_comb begin
        pulse_out = enable && (phase == PH_HIGH);
    end

endmodule

// File: rtl/pulse_train_checker.sv
// Assertions for pulse_train_gen, attached through bind.
// Assumes: cnt_zero is the counter's last-cycle flag inside the top module.
module pulse_train_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [LEN_W-1:0] high_len,
    input logic [LEN_W-1:0] low_len,
    input logic             pulse_out,
    input logic             cnt_zero
);

    // R8: disabled means silent in the same cycle
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pulse_out);

    // R2: first enabled edge starts the high phase
    p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (pulse_out || !enable));

    // R3: a high phase ends only when its count is spent
    p_fall_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_out) && enable && $past(enable)) |-> $past(cnt_zero));

    // R4: a low phase ends only when its count is spent
    p_rise_on_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_out) && $past(enable)) |-> $past(cnt_zero));

    // R5: zero high length gives a single high cycle
    p_zero_high_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(pulse_out) && !$past(pulse_out, 2) && ($past(high_len, 2) == '0))
        |-> !pulse_out);

    // R6: zero low length gives a single low cycle
    p_zero_low_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(enable, 2) && !$past(pulse_out)
         && $past(pulse_out, 2) && ($past(low_len, 2) == '0))
        |-> pulse_out);

endmodule

bind pulse_train_gen pulse_train_checker #(.LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .high_len  (high_len),
    .low_len   (low_len),
    .pulse_out (pulse_out),
    .cnt_zero  (cnt_zero)
);

// File: tb/pulse_train_gen_tb.sv
module pulse_train_gen_tb_top;

    localparam int LEN_W = 16;
    localparam int NROWS = 6;
    localparam int NSAMP = 20;

    // Table of programmed lengths; expected output is derived per cycle.
    localparam logic [LEN_W-1:0] TAB_H [NROWS] = '{16'd3, 16'd1, 16'd5, 16'd0, 16'd2, 16'd0};
    localparam logic [LEN_W-1:0] TAB_L [NROWS] = '{16'd3, 16'd4, 16'd1, 16'd3, 16'd0, 16'd0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [LEN_W-1:0] high_len = '0;
    logic [LEN_W-1:0] low_len = '0;
    logic             pulse_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_train_gen #(.LEN_W(LEN_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .high_len  (high_len),
        .low_len   (low_len),
        .pulse_out (pulse_out)
    );

    task automatic check(input logic actual, input logic expected, input string req);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: pulse_out=%0b expected %0b at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic logic model(input int h, input int l, input int i);
        int he = (h == 0) ? 1 : h;
        int le = (l == 0) ? 1 : l;
        return ((i % (he + le)) < he);
    endfunction

    function automatic string tag_of(input int h, input int l);
        if (h == 0 && l == 0) return "R7";
        if (h == 0) return "R5";
        if (l == 0) return "R6";
        return "R3 R4";
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(pulse_out, 1'b0, "R1");

        // Table walk: each row enabled from a stopped state (R2 start).
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            enable   = 1'b0;
            high_len = TAB_H[r];
            low_len  = TAB_L[r];
            @(negedge clk);
            enable = 1'b1;
            for (int i = 0; i < NSAMP; i++) begin
                @(negedge clk);
                check(pulse_out, model(int'(TAB_H[r]), int'(TAB_L[r]), i),
                      (i == 0) ? "R2" : tag_of(int'(TAB_H[r]), int'(TAB_L[r])));
            end
        end

        // R8: drop enable mid high phase, output clears at once, restart is full
        @(negedge clk);
        enable = 1'b0;
        high_len = 16'd4;
        low_len  = 16'd2;
        @(negedge clk);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        check(pulse_out, 1'b1, "R8");
        enable = 1'b0;
        #1;
        check(pulse_out, 1'b0, "R8");
        @(negedge clk);
        check(pulse_out, 1'b0, "R8");
        enable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(pulse_out, model(4, 2, i), "R8");
        end

        // R9: length change inside a phase only affects later phases
        @(negedge clk);
        enable = 1'b0;
        high_len = 16'd5;
        low_len  = 16'd3;
        @(negedge clk);
        enable = 1'b1;
        for (int i = 0; i < 14; i++) begin
            logic e;
            @(negedge clk);
            if (i < 5) e = 1'b1;
            else if (i < 8) e = 1'b0;
            else if (i == 8) e = 1'b1;
            else if (i < 12) e = 1'b0;
            else e = (i == 12);
            check(pulse_out, e, "R9");
            if (i == 1) high_len = 16'd1;
        end

        // R10: enable tied high through reset
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b1;
        high_len = 16'd2;
        low_len  = 16'd2;
        repeat (2) @(negedge clk);
        check(pulse_out, 1'b0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(pulse_out, model(2, 2, i), "R10");
        end

        done = 1'b1;
    end

    // Ends the run with the summary, counting a hung run as a failure.
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule